// File: doc/BRIEF.md
# Character LCD Nibble Interface Controller

This block connects a host to a character LCD panel wired with only four data lines plus enable, read/write and register-select strobes. The host offers one byte at a time with a flag saying whether it is a command or a character, using a valid/ready handshake. For every byte the controller first asks the panel whether it is still busy. It releases the data lines, reads the busy flag on the top data line, and repeats the read while the flag stays set. It then splits the byte into two nibbles, high half first, and clocks each nibble in with its own enable pulse. Pulse width and gap come from nanosecond parameters and the clock period.

A separate one-shot request sends the single nibble that switches a freshly powered panel into four-bit operation. A small text buffer, loaded through its own write port, can be streamed to the panel as characters. Streaming stops at the first zero byte or at the end of the buffer. A panel that never reports ready cannot stall the controller: after a bounded number of busy reads it raises an error flag and goes back to idle.

Typical host commands are 0x01 (clear), 0x80 / 0xC0 (cursor to top / bottom line) and 0x0C / 0x0F (display on without / with a blinking cursor). The controller does not interpret them.

Top module: `lcd4_ctrl`

## Requirements
- R1: After reset, enable is low, read/write is 0 (write), the data lines are driven (output enable 1), `in_ready` is 1 and `busy_err` is 0.
- R2: An accepted byte is written as two enable pulses: bits [7:4] on `lcd_d_out` first, then bits [3:0]. `lcd_d_out[3]` carries panel line D7. Both pulses have read/write 0, output enable 1, and register select equal to `in_is_data` (0 command, 1 character).
- R3: Every enable pulse stays high for exactly ceil(EN_HIGH_NS/CLK_NS) cycles and is followed by at least ceil(EN_GAP_NS/CLK_NS) low cycles. Register select, read/write, output enable and data are stable from at least one cycle before enable rises until it falls.
- R4: A pulse on `init_start` in idle produces exactly one enable pulse with nibble 0x2, register select 0 and read/write 0, with no busy read before it.
- R5: Before every byte write the controller performs busy reads. Each read is two enable pulses with output enable 0, read/write 1 and register select 0, and `lcd_d7_in` is sampled during the first pulse.
- R6: While the sampled busy bit is 1, the two-pulse read repeats. The byte write starts only after a read that returns 0.
- R7: After POLL_LIMIT consecutive busy reads for one byte, `busy_err` goes to 1, no nibble is written, and the controller returns to idle. `busy_err` returns to 0 when the next request is accepted.
- R8: `in_ready` is 0 from the cycle after a byte is accepted until the gap after the low-nibble pulse has ended. It is never 1 while enable is high.
- R9: A pulse on `str_start` sends buffer bytes from address 0 upward as characters (register select 1), each preceded by busy reads. Sending stops before the first 0x00 byte, or after address BUF_DEPTH-1 when the buffer holds no zero.
- R10: A `str_start` whose buffer entry 0 is 0x00 produces no enable pulse and leaves `in_ready` at 1.
- R11: Idle priority: `init_start` is taken before `in_valid`, and `in_valid` before `str_start`. `in_ready` is 0 in a cycle where `init_start` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_start | input | 1 | One-shot request to send the four-bit mode nibble |
| in_valid | input | 1 | Host byte valid |
| in_ready | output | 1 | Controller can accept a byte |
| in_byte | input | 8 | Byte to send |
| in_is_data | input | 1 | 1 = character, 0 = command |
| str_wr_en | input | 1 | Text buffer write strobe |
| str_wr_addr | input | $clog2(BUF_DEPTH) | Text buffer write address |
| str_wr_data | input | 8 | Text buffer write byte |
| str_start | input | 1 | Start streaming the text buffer |
| busy_err | output | 1 | Busy poll timed out |
| lcd_en | output | 1 | Panel enable strobe |
| lcd_rw | output | 1 | Panel read/write, 1 = read |
| lcd_rs | output | 1 | Panel register select, 1 = character data |
| lcd_d_out | output | 4 | Nibble driven onto panel lines D4..D7 (bit 3 = D7) |
| lcd_d_oe | output | 1 | 1 = drive data lines, 0 = released |
| lcd_d7_in | input | 1 | Level read back from panel line D7 (busy flag) |

## Verification
The assertions check on every cycle that the strobe lines stay frozen around and during each enable pulse and that each pulse has the exact high width. They also check that the data lines are released only in read mode, that reads always use register select 0, that the host is never offered ready while enable is high, and that an error appears only directly after a read. Only the bench scenarios can show the nibble order and values, the number of busy-read pairs for a given busy pattern, the stop points of the streamed text, and the timeout count. The bench does this by comparing every enable pulse against an expected-pulse queue while a panel model answers the busy reads.

// File: rtl/lcd4_pkg.sv
package lcd4_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_INIT,
        S_POLL_A,
        S_POLL_B,
        S_SEND_HI,
        S_SEND_LO
    } ctl_state_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_HIGH,
        PH_GAP
    } strobe_ph_e;

    // Levels presented to the panel besides the enable strobe
    typedef struct packed {
        logic       rs;
        logic       rw;
        logic       oe;
        logic [3:0] nib;
    } bus_drive_t;

    // Byte waiting to go out
    typedef struct packed {
        logic [7:0] code;
        logic       is_data;
    } xfer_t;

    localparam logic [3:0] FOUR_BIT_NIB = 4'h2;

    function automatic int ns_to_cycles(input int ns, input int period_ns);
        int c;
        c = (ns + period_ns - 1) / period_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic logic [3:0] pick_nibble(input logic [7:0] b, input logic upper);
        return upper ? b[7:4] : b[3:0];
    endfunction

endpackage

// File: rtl/lcd4_strobe.sv
module lcd4_strobe
    import lcd4_pkg::*;
#(
    parameter int SETUP_CYC = 1,
    parameter int HIGH_CYC  = 19,
    parameter int GAP_CYC   = 8,
    parameter int CW        = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic launch,
    output logic en,
    output logic sample,
    output logic done,
    output logic active
);

    strobe_ph_e     ph;
    logic [CW-1:0]  cnt;
    logic [CW-1:0]  lim;
    logic           last;

    always_comb begin
        case (ph)
            PH_SETUP: lim = CW'(SETUP_CYC - 1);
            PH_HIGH:  lim = CW'(HIGH_CYC - 1);
            PH_GAP:   lim = CW'(GAP_CYC - 1);
            default:  lim = '0;
        endcase
    end

    assign last = (cnt == lim);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph  <= PH_IDLE;
            cnt <= '0;
        end else begin
            case (ph)
                PH_IDLE: begin
                    cnt <= '0;
                    if (launch) ph <= PH_SETUP;
                end
                default: begin
                    if (last) begin
                        cnt <= '0;
                        case (ph)
                            PH_SETUP: ph <= PH_HIGH;
                            PH_HIGH:  ph <= PH_GAP;
                            default:  ph <= PH_IDLE;
                        endcase
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    assign en     = (ph == PH_HIGH);
    assign sample = en && last;
    assign done   = (ph == PH_GAP) && last;
    assign active = (ph != PH_IDLE);

endmodule

// File: rtl/lcd4_strbuf.sv
module lcd4_strbuf #(
    parameter int DEPTH = 8,
    parameter int AW    = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/lcd4_ctrl.sv
module lcd4_ctrl
    import lcd4_pkg::*;
#(
    parameter int CLK_NS     = 20,
    parameter int EN_HIGH_NS = 375,
    parameter int EN_GAP_NS  = 150,
    parameter int SETUP_CYC  = 1,
    parameter int POLL_LIMIT = 8,
    parameter int BUF_DEPTH  = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         init_start,
    input  logic                         in_valid,
    output logic                         in_ready,
    input  logic [7:0]                   in_byte,
    input  logic                         in_is_data,
    input  logic                         str_wr_en,
    input  logic [$clog2(BUF_DEPTH)-1:0] str_wr_addr,
    input  logic [7:0]                   str_wr_data,
    input  logic                         str_start,
    output logic                         busy_err,
    output logic                         lcd_en,
    output logic                         lcd_rw,
    output logic                         lcd_rs,
    output logic [3:0]                   lcd_d_out,
    output logic                         lcd_d_oe,
    input  logic                         lcd_d7_in
);

    localparam int HIGH_CYC = ns_to_cycles(EN_HIGH_NS, CLK_NS);
    localparam int GAP_CYC  = ns_to_cycles(EN_GAP_NS, CLK_NS);
    localparam int CW       = $clog2(max3(SETUP_CYC, HIGH_CYC, GAP_CYC) + 1);
    localparam int AW       = $clog2(BUF_DEPTH);
    localparam int PW       = $clog2(POLL_LIMIT + 1);

    ctl_state_e     state;
    xfer_t          cur;
    logic [AW-1:0]  ptr;
    logic [AW-1:0]  rd_addr;
    logic [7:0]     rd_data;
    logic           streaming;
    logic           busy_seen;
    logic [PW-1:0]  poll_cnt;
    logic           launch, st_sample, st_done, st_active;
    bus_drive_t     drv;

    assign launch = (state != S_IDLE) && !st_active;

    lcd4_strobe #(
        .SETUP_CYC (SETUP_CYC),
        .HIGH_CYC  (HIGH_CYC),
        .GAP_CYC   (GAP_CYC),
        .CW        (CW)
    ) u_strobe (
        .clk    (clk),
        .rst    (rst),
        .launch (launch),
        .en     (lcd_en),
        .sample (st_sample),
        .done   (st_done),
        .active (st_active)
    );

    // In idle the buffer head is examined; while streaming, the next entry
    assign rd_addr = (state == S_IDLE) ? '0 : ptr + AW'(1);

    lcd4_strbuf #(
        .DEPTH (BUF_DEPTH),
        .AW    (AW)
    ) u_buf (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (str_wr_en),
        .wr_addr (str_wr_addr),
        .wr_data (str_wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    always_comb begin
        drv = '{rs: 1'b0, rw: 1'b0, oe: 1'b1, nib: 4'h0};
        case (state)
            S_INIT:    drv.nib = FOUR_BIT_NIB;
            S_POLL_A,
            S_POLL_B:  begin
                drv.rw = 1'b1;
                drv.oe = 1'b0;
            end
            S_SEND_HI: begin
                drv.rs  = cur.is_data;
                drv.nib = pick_nibble(cur.code, 1'b1);
            end
            S_SEND_LO: begin
                drv.rs  = cur.is_data;
                drv.nib = pick_nibble(cur.code, 1'b0);
            end
            default: ;
        endcase
    end

    assign lcd_rs    = drv.rs;
    assign lcd_rw    = drv.rw;
    assign lcd_d_oe  = drv.oe;
    assign lcd_d_out = drv.nib;
    assign in_ready  = (state == S_IDLE) && !init_start;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_IDLE;
            cur       <= '0;
            ptr       <= '0;
            streaming <= 1'b0;
            busy_seen <= 1'b0;
            poll_cnt  <= '0;
            busy_err  <= 1'b0;
        end else begin
            case (state)
                S_IDLE: begin
                    if (init_start) begin
                        busy_err <= 1'b0;
                        state    <= S_INIT;
                    end else if (in_valid) begin
                        busy_err  <= 1'b0;
                        cur       <= '{code: in_byte, is_data: in_is_data};
                        streaming <= 1'b0;
                        poll_cnt  <= '0;
                        state     <= S_POLL_A;
                    end else if (str_start) begin
                        busy_err <= 1'b0;
                        if (rd_data != 8'h00) begin
                            cur       <= '{code: rd_data, is_data: 1'b1};
                            ptr       <= '0;
                            streaming <= 1'b1;
                            poll_cnt  <= '0;
                            state     <= S_POLL_A;
                        end
                    end
                end
                S_INIT: if (st_done) state <= S_IDLE;
                S_POLL_A: begin
                    if (st_sample) busy_seen <= lcd_d7_in;
                    if (st_done)   state     <= S_POLL_B;
                end
                S_POLL_B: begin
                    if (st_done) begin
                        if (!busy_seen) begin
                            state <= S_SEND_HI;
                        end else if (poll_cnt == PW'(POLL_LIMIT - 1)) begin
                            busy_err  <= 1'b1;
                            streaming <= 1'b0;
                            state     <= S_IDLE;
                        end else begin
                            poll_cnt <= poll_cnt + 1'b1;
                            state    <= S_POLL_A;
                        end
                    end
                end
                S_SEND_HI: if (st_done) state <= S_SEND_LO;
                S_SEND_LO: begin
                    if (st_done) begin
                        if (streaming && (ptr != AW'(BUF_DEPTH - 1)) && (rd_data != 8'h00)) begin
                            ptr      <= ptr + AW'(1);
                            cur      <= '{code: rd_data, is_data: 1'b1};
                            poll_cnt <= '0;
                            state    <= S_POLL_A;
                        end else begin
                            streaming <= 1'b0;
                            state     <= S_IDLE;
                        end
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/lcd4_ctrl_chk.sv
module lcd4_ctrl_chk #(
    parameter int HIGH_CYC = 19
) (
    input logic       clk,
    input logic       rst,
    input logic       lcd_en,
    input logic       lcd_rs,
    input logic       lcd_rw,
    input logic       lcd_d_oe,
    input logic [3:0] lcd_d_out,
    input logic       in_ready,
    input logic       busy_err
);

    logic [15:0] hi_len;

    always_ff @(posedge clk) begin
        if (rst)         hi_len <= '0;
        else if (lcd_en) hi_len <= hi_len + 1'b1;
        else             hi_len <= '0;
    end

    // R3
    lines_stable_chk: assert property (@(posedge clk) disable iff (rst)
        lcd_en |-> $stable({lcd_rs, lcd_rw, lcd_d_oe, lcd_d_out}));

    // R3
    pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(lcd_en) |-> (hi_len == 16'(HIGH_CYC)));

    // R3
    pulse_bound_chk: assert property (@(posedge clk) disable iff (rst)
        lcd_en |-> (hi_len < 16'(HIGH_CYC)));

    // R5
    bus_release_chk: assert property (@(posedge clk) disable iff (rst)
        lcd_rw == !lcd_d_oe);

    // R5
    read_cmd_reg_chk: assert property (@(posedge clk) disable iff (rst)
        (lcd_en && lcd_rw) |-> !lcd_rs);

    // R8
    no_ready_in_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        lcd_en |-> !in_ready);

    // R7
    err_after_read_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_err) |-> ($past(lcd_rw) && !lcd_en));

endmodule

bind lcd4_ctrl lcd4_ctrl_chk #(.HIGH_CYC(HIGH_CYC)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .lcd_en    (lcd_en),
    .lcd_rs    (lcd_rs),
    .lcd_rw    (lcd_rw),
    .lcd_d_oe  (lcd_d_oe),
    .lcd_d_out (lcd_d_out),
    .in_ready  (in_ready),
    .busy_err  (busy_err)
);

// File: tb/sim_lcd4_ctrl.sv
module sim_lcd4_ctrl;

    localparam int CLK_PERIOD = 20;
    localparam int HI_EXP     = (375 + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int GAP_EXP    = (150 + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int PLIM       = 8;
    localparam int DEPTH      = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       init_start = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_byte = 8'h00;
    logic       in_is_data = 1'b0;
    logic       str_wr_en = 1'b0;
    logic [2:0] str_wr_addr = 3'd0;
    logic [7:0] str_wr_data = 8'h00;
    logic       str_start = 1'b0;
    logic       busy_err;
    logic       lcd_en, lcd_rw, lcd_rs, lcd_d_oe, lcd_d7_in;
    logic [3:0] lcd_d_out;

    int tests = 0;
    int fails = 0;
    int pulses = 0;
    int busy_polls = 0;
    int cycles = 0;
    bit finished = 0;

    typedef struct {
        logic       rs;
        logic       rw;
        logic       oe;
        logic [3:0] nib;
        bit         cmp_nib;
        string      tag;
    } exp_t;

    exp_t sbq[$];

    assign lcd_d7_in = (busy_polls > 0);

    always #(CLK_PERIOD / 2) clk = ~clk;

    lcd4_ctrl #(
        .CLK_NS     (CLK_PERIOD),
        .POLL_LIMIT (PLIM),
        .BUF_DEPTH  (DEPTH)
    ) u0 (
        .clk         (clk),
        .rst         (rst),
        .init_start  (init_start),
        .in_valid    (in_valid),
        .in_ready    (in_ready),
        .in_byte     (in_byte),
        .in_is_data  (in_is_data),
        .str_wr_en   (str_wr_en),
        .str_wr_addr (str_wr_addr),
        .str_wr_data (str_wr_data),
        .str_start   (str_start),
        .busy_err    (busy_err),
        .lcd_en      (lcd_en),
        .lcd_rw      (lcd_rw),
        .lcd_rs      (lcd_rs),
        .lcd_d_out   (lcd_d_out),
        .lcd_d_oe    (lcd_d_oe),
        .lcd_d7_in   (lcd_d7_in)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // ---------------- monitor: pops and compares each enable pulse
    bit en_q = 0;
    bit seen_fall = 0;
    bit rd_second = 0;
    int hi_run = 0;
    int lo_run = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (lcd_en && !en_q) begin
                pulses++;
                if (seen_fall) check(lo_run >= GAP_EXP, "R3 gap", lo_run, GAP_EXP);
                check(!in_ready, "R8 ready during pulse", in_ready, 0);
                if (sbq.size() == 0) begin
                    check(0, "R2 unexpected pulse", {lcd_rs, lcd_rw, lcd_d_oe, lcd_d_out}, 0);
                end else begin
                    exp_t e;
                    e = sbq.pop_front();
                    check(lcd_rs == e.rs && lcd_rw == e.rw && lcd_d_oe == e.oe &&
                          (!e.cmp_nib || lcd_d_out == e.nib), e.tag,
                          {lcd_rs, lcd_rw, lcd_d_oe, lcd_d_out},
                          {e.rs, e.rw, e.oe, e.nib});
                end
                if (lcd_rw) begin
                    if (rd_second && busy_polls > 0) busy_polls--;
                    rd_second = !rd_second;
                end
                lo_run = 0;
            end
            if (!lcd_en && en_q) begin
                check(hi_run == HI_EXP, "R3 high width", hi_run, HI_EXP);
                seen_fall = 1;
                hi_run = 0;
            end
            if (lcd_en) hi_run++;
            else        lo_run++;
            en_q = lcd_en;
        end
    end

    // ---------------- driver side
    task automatic push_polls(input int pairs);
        for (int i = 0; i < 2 * pairs; i++)
            sbq.push_back('{rs: 1'b0, rw: 1'b1, oe: 1'b0, nib: 4'h0, cmp_nib: 1'b0, tag: "R5 R6 busy read"});
    endtask

    task automatic push_byte(input logic [7:0] b, input logic isd, input string tag);
        sbq.push_back('{rs: isd, rw: 1'b0, oe: 1'b1, nib: b[7:4], cmp_nib: 1'b1, tag: tag});
        sbq.push_back('{rs: isd, rw: 1'b0, oe: 1'b1, nib: b[3:0], cmp_nib: 1'b1, tag: tag});
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!in_ready) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b, input logic isd, input int nbusy, input string tag);
        busy_polls = nbusy;
        push_polls(nbusy + 1);
        push_byte(b, isd, tag);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid   = 1'b1;
        in_byte    = b;
        in_is_data = isd;
        @(negedge clk);
        in_valid = 1'b0;
        check(!in_ready, "R8 ready low after accept", in_ready, 0);
        wait_idle();
        check(sbq.size() == 0, tag, sbq.size(), 0);
    endtask

    task automatic load(input int idx, input logic [7:0] v);
        @(negedge clk);
        str_wr_en   = 1'b1;
        str_wr_addr = idx[2:0];
        str_wr_data = v;
        @(negedge clk);
        str_wr_en = 1'b0;
    endtask

    task automatic kick_string();
        @(negedge clk);
        str_start = 1'b1;
        @(negedge clk);
        str_start = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    // ---------------- watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            finish_run();
        end
    end

    initial begin
        int p0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check(lcd_en == 0 && lcd_rw == 0 && lcd_d_oe == 1, "R1 strobes", {lcd_en, lcd_rw, lcd_d_oe}, 3'b001);
        check(in_ready == 1 && busy_err == 0, "R1 handshake", {in_ready, busy_err}, 2'b10);

        // R4 four-bit switch nibble, single pulse, no busy read
        p0 = pulses;
        sbq.push_back('{rs: 1'b0, rw: 1'b0, oe: 1'b1, nib: 4'h2, cmp_nib: 1'b1, tag: "R4 init nibble"});
        init_start = 1'b1;
        in_valid   = 1'b1;
        in_byte    = 8'hAA;
        // R11 init wins over a simultaneous byte; ready is low while init_start is high
        #1 check(!in_ready, "R11 ready with init_start", in_ready, 0);
        @(negedge clk);
        init_start = 1'b0;
        in_valid   = 1'b0;
        wait_idle();
        check(pulses - p0 == 1, "R4 R11 single pulse", pulses - p0, 1);

        // R2 R5 commands with no busy
        send_byte(8'h01, 1'b0, 0, "R2 cmd clear");
        send_byte(8'hC0, 1'b0, 0, "R2 cmd bottom line");
        // R6 busy for several reads before write
        send_byte(8'h41, 1'b1, 3, "R6 R2 data after busy");
        send_byte(8'h0C, 1'b0, 1, "R6 cmd after one busy");

        // R7 timeout
        busy_polls = 1000;
        push_polls(PLIM);
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = 8'h80;
        @(negedge clk);
        in_valid = 1'b0;
        wait_idle();
        check(busy_err == 1, "R7 error raised", busy_err, 1);
        check(sbq.size() == 0, "R7 read pairs", sbq.size(), 0);
        busy_polls = 0;
        send_byte(8'h0F, 1'b0, 0, "R7 R2 send after timeout");
        check(busy_err == 0, "R7 error cleared", busy_err, 0);

        // R9 string terminated by zero
        load(0, 8'h48);
        load(1, 8'h49);
        load(2, 8'h00);
        load(3, 8'h5A);
        push_polls(1); push_byte(8'h48, 1'b1, "R9 char 0");
        push_polls(1); push_byte(8'h49, 1'b1, "R9 char 1");
        kick_string();
        wait_idle();
        check(sbq.size() == 0, "R9 stop at zero", sbq.size(), 0);

        // R9 buffer with no zero: all entries sent
        for (int i = 0; i < DEPTH; i++) begin
            load(i, 8'h30 + 8'(i));
            push_polls(1);
            push_byte(8'h30 + 8'(i), 1'b1, "R9 full buffer");
        end
        kick_string();
        wait_idle();
        check(sbq.size() == 0, "R9 end of buffer", sbq.size(), 0);

        // R10 empty string
        load(0, 8'h00);
        p0 = pulses;
        kick_string();
        repeat (60) @(negedge clk);
        check(pulses == p0, "R10 no pulses", pulses - p0, 0);
        check(in_ready == 1, "R10 ready stays high", in_ready, 1);

        // R11 byte wins over string start
        load(0, 8'h55);
        push_polls(1);
        push_byte(8'h80, 1'b0, "R11 byte before string");
        @(negedge clk);
        in_valid   = 1'b1;
        in_byte    = 8'h80;
        in_is_data = 1'b0;
        str_start  = 1'b1;
        @(negedge clk);
        in_valid  = 1'b0;
        str_start = 1'b0;
        wait_idle();
        check(sbq.size() == 0, "R11 only byte sent", sbq.size(), 0);

        repeat (20) @(negedge clk);
        check(sbq.size() == 0, "R2 queue drained", sbq.size(), 0);
        finish_run();
    end

endmodule